// File: doc/BRIEF.md
# Paged SPI Register Access Slave

This block is an SPI slave that gives an external controller byte-wide access to a 64 KB internal register space. Every transaction starts with a command field. Its first bit selects the direction: 0 writes and 1 reads. The rest of the command field is a register offset. A local page register supplies the address bits that the command field cannot carry.

In short-offset mode the command is one byte. Its low 7 bits are the offset, and the page register gives the upper 9 address bits. In long-offset mode the command is two bytes. They carry a 15-bit offset, and the page register gives only address bit 15. The page register appears in a small window at the top of every page, so it can always be reached. A page update takes effect only when a complete burst writes the whole window and carries the two fixed tag bytes.

Data bytes follow the command. The address pointer advances after each byte. Read data is fetched from the internal bus one byte ahead of the serial stream. A configuration input selects the SCLK edge on which data is sampled. Another selects whether read data leaves on the shared bidirectional data pin (3-wire) or on a dedicated output (4-wire). The serial inputs are synchronised to the system clock. This clock must run at least eight times faster than SCLK.

Top module: `spi_paged_slave`

## Requirements
- R1: After reset both data output enables are low, no bus cycle occurs, and the page register is zero, so a short-offset write to offset 05h lands at bus address 0005h.
- R2: The most significant bit of the first command byte selects the direction: 0 means write and 1 means read.
- R3: In short-offset mode the bus address is {page[8:0], offset[6:0]}. With the page set from window bytes 80h, CBh, the command 64h followed by data 50h writes 50h to CBE4h.
- R4: In short-offset mode, offsets 7Ch–7Fh reach the page window. Bit 7 of the byte at 7Ch is page bit 0, and the byte at 7Dh is page bits [8:1]. The bytes at 7Eh and 7Fh must be 10h and 20h. The page changes only after a burst that starts at 7Ch and writes all four bytes with correct tags. A read of the window returns {page[0],0000000b}, page[8:1], 10h, 20h.
- R5: In long-offset mode the bus address is {page[8], offset[14:0]}, with the offset taken from the two command bytes, most significant byte first.
- R6: In long-offset mode the window is 7FFDh–7FFFh. Bit 7 of the byte at 7FFDh is page bit 8, and the tags 10h and 20h follow. Only a 3-byte burst that starts at 7FFDh commits. A burst that starts at 7FFCh writes its first byte to the bus and leaves the page unchanged.
- R7: The offset increments after every data byte. In short-offset mode only the 7 offset bits increment, so a burst never leaves its page.
- R8: A read sends data MSB first. The first byte comes from the command address and is driven before the first data sample edge. Later bytes come from consecutive addresses, each fetched with one bus read pulse at the byte boundary.
- R9: cfg_sample_fall = 0 samples input data on rising SCLK and changes output data on falling SCLK. A value of 1 swaps the two edges.
- R10: With cfg_three_wire = 1, read data is driven on spi_sdio_out with spi_sdio_oe high. With 0, it is driven on spi_sdo with spi_sdo_oe high. The other enable stays low.
- R11: Raising spi_cs_n ends the transaction at any bit. A partial data byte is dropped without a bus write, and both output enables fall.
- R12: Page window bytes never produce a bus cycle, and bus_wr and bus_rd are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_two_byte | input | 1 | 1 = two-byte command with 15-bit offset, 0 = one-byte command with 7-bit offset |
| cfg_sample_fall | input | 1 | 1 = sample on falling SCLK, 0 = sample on rising SCLK |
| cfg_three_wire | input | 1 | 1 = read data on the shared data pin, 0 = read data on spi_sdo |
| spi_sclk | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdio_in | input | 1 | Serial data input (input side of the shared pin) |
| spi_sdio_out | output | 1 | Read data for the shared pin in 3-wire mode |
| spi_sdio_oe | output | 1 | Output enable for the shared pin |
| spi_sdo | output | 1 | Read data pin for 4-wire mode |
| spi_sdo_oe | output | 1 | Output enable for spi_sdo |
| bus_addr | output | 16 | Internal bus byte address |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe; bus_rdata is taken in the same cycle |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data returned for bus_addr |

## Verification
All four combinations of sampling edge and wire count are swept, and every sweep runs in both offset modes. Short-offset writes and two-byte reads are spread over the whole offset range below the window. These separate a correct {page, offset} join from a shifted or truncated one, and they show that read bytes come out MSB first from consecutive addresses. Page window bursts are sent four ways: complete, short by one byte, with a wrong tag, and started one byte too early. Only the complete burst may move later addresses. Aborted transfers check that a partial byte never reaches the bus and that the data pins are released.

// File: rtl/spi_pg_pkg.sv
package spi_pg_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int SHORT_W = 7;
  localparam int OFF_W   = ADDR_W - 1;
  localparam int PG_W    = ADDR_W - SHORT_W;
  localparam int HCNT_W  = $clog2(2 * DATA_W);

  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [PG_W-1:0]   pg_t;
  typedef logic [DATA_W-1:0] byte_t;

  localparam byte_t TAG_LO = 8'h10;
  localparam byte_t TAG_HI = 8'h20;
  localparam off_t  WIN_SHORT_BASE = 15'h007C;
  localparam off_t  WIN_LONG_BASE  = 15'h7FFD;

  // Join page and offset into a bus address.
  function automatic logic [ADDR_W-1:0] join_addr(input logic two, input pg_t pg, input off_t off);
    return two ? {pg[PG_W-1], off} : {pg, off[SHORT_W-1:0]};
  endfunction

  // Advance an offset; short mode wraps inside the 7-bit page.
  function automatic off_t step_off(input logic two, input off_t off);
    off_t r;
    r = two ? off + 15'd1 : {8'd0, off[SHORT_W-1:0] + 7'd1};
    return r;
  endfunction

  function automatic logic is_window(input logic two, input off_t off);
    return two ? (off >= WIN_LONG_BASE) : (off[SHORT_W-1:2] == 5'b11111);
  endfunction

  function automatic off_t window_base(input logic two);
    return two ? WIN_LONG_BASE : WIN_SHORT_BASE;
  endfunction

  // Position inside the window, 0 for its first byte.
  function automatic logic [1:0] window_pos(input logic two, input logic [1:0] lo);
    return two ? lo - 2'd1 : lo;
  endfunction

  function automatic logic [1:0] window_last(input logic two);
    return two ? 2'd2 : 2'd3;
  endfunction

  function automatic logic is_tag_pos(input logic two, input logic [1:0] pos);
    return two ? (pos != 2'd0) : (pos[1] == 1'b1);
  endfunction

  function automatic byte_t tag_for(input logic two, input logic [1:0] pos);
    return (pos == window_last(two)) ? TAG_HI : TAG_LO;
  endfunction
endpackage

// File: rtl/spi_pg_sync.sv
module spi_pg_sync
  import spi_pg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_fall,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic cs_act,
  output logic smp_edge,
  output logic shf_edge,
  output logic din
);
  // Each stage holds {sclk, cs_n, sdi}.
  logic [2:0] st [SYNC_STAGES];
  logic       sclk_prev;
  logic       rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) st[i] <= 3'b010;
      sclk_prev <= 1'b0;
    end else begin
      st[0] <= {sclk, cs_n, sdi};
      for (int i = 1; i < SYNC_STAGES; i++) st[i] <= st[i-1];
      sclk_prev <= st[SYNC_STAGES-1][2];
    end
  end

  assign rise     = st[SYNC_STAGES-1][2] & ~sclk_prev;
  assign fall     = ~st[SYNC_STAGES-1][2] & sclk_prev;
  assign cs_act   = ~st[SYNC_STAGES-1][1];
  assign din      = st[SYNC_STAGES-1][0];
  assign smp_edge = cs_act & (sample_fall ? fall : rise);
  assign shf_edge = cs_act & (sample_fall ? rise : fall);
endmodule

// File: rtl/spi_pg_page.sv
module spi_pg_page
  import spi_pg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       two,
  input  logic [1:0] acc_lo,
  input  logic       hdr_done,
  input  logic       base_start,
  input  logic       win_wr,
  input  byte_t      wdata,
  output pg_t        pg,
  output byte_t      win_rdata
);
  pg_t        stg;
  logic       tags_ok, from_base;
  logic [1:0] pos;
  logic       tag_good, commit;

  assign pos      = window_pos(two, acc_lo);
  assign tag_good = !is_tag_pos(two, pos) || (wdata == tag_for(two, pos));
  assign commit   = win_wr && from_base && tags_ok && tag_good && (pos == window_last(two));

  always_comb begin
    if (two) begin
      win_rdata = (pos == 2'd0) ? {pg[PG_W-1], 7'd0} : tag_for(two, pos);
    end else begin
      case (pos)
        2'd0:    win_rdata = {pg[0], 7'd0};
        2'd1:    win_rdata = pg[PG_W-1:1];
        default: win_rdata = tag_for(two, pos);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg       <= '0;
      pg        <= '0;
      tags_ok   <= 1'b0;
      from_base <= 1'b0;
    end else begin
      if (hdr_done) begin
        tags_ok   <= 1'b1;
        from_base <= base_start;
      end else if (win_wr) begin
        if (!tag_good) tags_ok <= 1'b0;
        if (pos == 2'd0) begin
          if (two) stg[PG_W-1] <= wdata[7];
          else     stg[0]      <= wdata[7];
        end
        if (!two && pos == 2'd1) stg[PG_W-1:1] <= wdata;
      end
      if (commit) pg <= two ? {stg[PG_W-1], pg[PG_W-2:0]} : stg;
    end
  end

  // The page only moves right after a window byte was written.
  assert_page_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pg) |-> $past(win_wr));
endmodule

// File: rtl/spi_pg_frame.sv
module spi_pg_frame
  import spi_pg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two,
  input  logic              cs_act,
  input  logic              smp_edge,
  input  logic              shf_edge,
  input  logic              din,
  input  pg_t               pg,
  input  byte_t             win_rdata,
  input  byte_t             bus_rdata,
  output logic [1:0]        acc_lo,
  output logic              hdr_done,
  output logic              base_start,
  output logic              win_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_wr,
  output logic              bus_rd,
  output byte_t             bus_wdata,
  output logic              out_bit,
  output logic              out_en
);
  logic [HCNT_W-1:0] hcnt, hlast;
  logic              in_data, is_read;
  logic [2:0]        dcnt;
  logic [14:0]       rx_sr;
  off_t              ptr, acc_off, new_off;
  byte_t             tx_byte, rd_byte;
  logic [15:0]       hdr_val;
  logic              byte_done, new_rw, rd_now, access, acc_win, load;

  assign hlast     = two ? HCNT_W'(15) : HCNT_W'(7);
  assign hdr_val   = {rx_sr, din};
  assign hdr_done  = smp_edge && !in_data && (hcnt == hlast);
  assign byte_done = smp_edge && in_data && (dcnt == 3'd7);
  assign new_rw    = two ? hdr_val[15] : hdr_val[7];
  assign new_off   = two ? hdr_val[14:0] : {8'd0, hdr_val[6:0]};
  assign rd_now    = hdr_done ? new_rw : is_read;
  assign acc_off   = hdr_done ? new_off : (is_read ? step_off(two, ptr) : ptr);
  assign acc_lo    = acc_off[1:0];
  assign access    = (hdr_done && new_rw) || byte_done;
  assign acc_win   = is_window(two, acc_off);
  assign load      = access && rd_now;
  assign bus_rd    = load && !acc_win;
  assign bus_wr    = byte_done && !is_read && !acc_win;
  assign win_wr    = byte_done && !is_read && acc_win;
  assign rd_byte   = acc_win ? win_rdata : bus_rdata;
  assign base_start = (new_off == window_base(two));
  assign bus_addr  = join_addr(two, pg, acc_off);
  assign bus_wdata = hdr_val[7:0];
  assign out_en    = in_data && is_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt    <= '0;
      in_data <= 1'b0;
      is_read <= 1'b0;
      dcnt    <= '0;
      rx_sr   <= '0;
      ptr     <= '0;
      tx_byte <= '0;
      out_bit <= 1'b0;
    end else if (!cs_act) begin
      hcnt    <= '0;
      in_data <= 1'b0;
      is_read <= 1'b0;
      dcnt    <= '0;
    end else begin
      if (smp_edge) begin
        rx_sr <= hdr_val[14:0];
        if (!in_data) begin
          if (hdr_done) begin
            in_data <= 1'b1;
            is_read <= new_rw;
            ptr     <= new_off;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end else begin
          dcnt <= dcnt + 3'd1;
          if (byte_done) ptr <= step_off(two, ptr);
        end
      end
      if (load) begin
        tx_byte <= rd_byte;
        out_bit <= rd_byte[7];
      end else if (shf_edge && in_data && is_read) begin
        out_bit <= tx_byte[~dcnt];
      end
    end
  end

  assert_wr_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> cs_act);
  assert_rd_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> cs_act);
  assert_bus_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
endmodule

// File: rtl/spi_paged_slave.sv
module spi_paged_slave
  import spi_pg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_two_byte,
  input  logic        cfg_sample_fall,
  input  logic        cfg_three_wire,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_sdio_in,
  output logic        spi_sdio_out,
  output logic        spi_sdio_oe,
  output logic        spi_sdo,
  output logic        spi_sdo_oe,
  output logic [15:0] bus_addr,
  output logic        bus_wr,
  output logic        bus_rd,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata
);
  logic       cs_act, smp_edge, shf_edge, din;
  logic [1:0] acc_lo;
  logic       hdr_done, base_start, win_wr, out_bit, out_en;
  pg_t        pg;
  byte_t      win_rdata;

  spi_pg_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sample_fall(cfg_sample_fall),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .sdi(spi_sdio_in),
    .cs_act(cs_act), .smp_edge(smp_edge), .shf_edge(shf_edge), .din(din)
  );

  spi_pg_frame u_frame (
    .clk(clk), .rst_n(rst_n), .two(cfg_two_byte), .cs_act(cs_act),
    .smp_edge(smp_edge), .shf_edge(shf_edge), .din(din), .pg(pg),
    .win_rdata(win_rdata), .bus_rdata(bus_rdata), .acc_lo(acc_lo),
    .hdr_done(hdr_done), .base_start(base_start), .win_wr(win_wr),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .out_bit(out_bit), .out_en(out_en)
  );

  spi_pg_page u_page (
    .clk(clk), .rst_n(rst_n), .two(cfg_two_byte), .acc_lo(acc_lo),
    .hdr_done(hdr_done), .base_start(base_start), .win_wr(win_wr),
    .wdata(bus_wdata), .pg(pg), .win_rdata(win_rdata)
  );

  assign spi_sdio_out = out_bit;
  assign spi_sdo      = out_bit;
  assign spi_sdio_oe  = out_en & cfg_three_wire;
  assign spi_sdo_oe   = out_en & ~cfg_three_wire;

  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !(spi_sdo_oe || spi_sdio_oe));
  assert_pin_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(spi_sdo_oe && spi_sdio_oe));
endmodule

// File: tb/spi_paged_slave_tb.sv
`timescale 1ns/1ps
module spi_paged_slave_tb;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_two_byte = 1'b0, cfg_sample_fall = 1'b0, cfg_three_wire = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_sdio_in = 1'b0;
  logic spi_sdio_out, spi_sdio_oe, spi_sdo, spi_sdo_oe;
  logic [15:0] bus_addr;
  logic bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;

  int checks = 0, errors = 0;
  int wn = 0;
  logic [15:0] wa [8];
  logic [7:0]  wd [8];
  logic [7:0]  rxb [6];
  logic        oe_bad;
  logic        idle;
  logic [8:0]  bpg;

  always #5 clk = ~clk;

  function automatic logic [7:0] fmem(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction
  assign bus_rdata = fmem(bus_addr);

  spi_paged_slave u_dut (.*);

  always @(negedge clk) begin
    if (bus_wr && wn < 8) begin
      wa[wn] = bus_addr;
      wd[wn] = bus_wdata;
      wn++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic dpin();
    return cfg_three_wire ? spi_sdio_out : spi_sdo;
  endfunction

  function automatic logic oe_right();
    return cfg_three_wire ? (spi_sdio_oe && !spi_sdo_oe) : (spi_sdo_oe && !spi_sdio_oe);
  endfunction

  task automatic xfer(input int nb, input int hb, input int stop,
                      input logic [7:0] b0, b1, b2, b3, b4, b5);
    logic [7:0] tb [6];
    logic rd;
    tb = '{b0, b1, b2, b3, b4, b5};
    rd = b0[7];
    wn = 0;
    oe_bad = 1'b0;
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int b = 0; b < nb * 8; b++) begin
      if (b == stop) break;
      spi_sdio_in = tb[b / 8][7 - (b % 8)];
      repeat (H) @(negedge clk);
      if (b >= hb * 8) begin
        rxb[b / 8 - hb][7 - (b % 8)] = dpin();
        if (rd && !oe_right()) oe_bad = 1'b1;
      end
      spi_sclk = ~idle;
      repeat (H) @(negedge clk);
      spi_sclk = idle;
    end
    repeat (H) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (H + 2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      cfg_sample_fall = c[0];
      cfg_three_wire  = c[1];
      cfg_two_byte    = 1'b0;
      idle = c[0];
      spi_sclk = idle;
      spi_cs_n = 1'b1;
      wn = 0;
      do_reset();
      bpg = 9'd0;
      // R1: reset state
      chk("R1 oe", {30'd0, spi_sdo_oe, spi_sdio_oe}, 0);
      chk("R1 bus", wn, 0);
      xfer(2, 1, -1, 8'h05, 8'h11, 0, 0, 0, 0);
      chk("R1 cnt", wn, 1);
      chk("R1 addr", wa[0], 16'h0005);
      chk("R2 wdata", wd[0], 8'h11);
      // R4: full page burst
      xfer(5, 1, -1, 8'h7C, 8'h80, 8'hCB, 8'h10, 8'h20, 0);
      bpg = {8'hCB, 1'b1};
      chk("R12 window no bus", wn, 0);
      // R3 / R9: worked example on the selected edge
      xfer(2, 1, -1, 8'h64, 8'h50, 0, 0, 0, 0);
      chk("R9 cnt", wn, 1);
      chk("R3 addr", wa[0], 16'hCBE4);
      chk("R3 data", wd[0], 8'h50);
      // R4: window readback
      xfer(5, 1, -1, 8'hFC, 0, 0, 0, 0, 0);
      chk("R4 rd0", rxb[0], 8'h80);
      chk("R4 rd1", rxb[1], 8'hCB);
      chk("R4 rd2", rxb[2], 8'h10);
      chk("R4 rd3", rxb[3], 8'h20);
      chk("R10 oe", oe_bad, 0);
      // R3 / R8 sweep over short offsets
      for (int o = 0; o < 8'h7C; o += 5) begin
        xfer(2, 1, -1, 8'(o), 8'(o) ^ 8'h3C, 0, 0, 0, 0);
        chk("R3 sweep cnt", wn, 1);
        chk("R3 sweep addr", wa[0], {bpg, 7'(o)});
        chk("R2 sweep data", wd[0], 8'(o) ^ 8'h3C);
        xfer(3, 1, -1, 8'h80 | 8'(o), 0, 0, 0, 0, 0);
        chk("R8 rd0", rxb[0], fmem({bpg, 7'(o)}));
        chk("R8 rd1", rxb[1], fmem({bpg, 7'(o + 1)}));
        chk("R2 no write on read", wn, 0);
        chk("R10 pins", oe_bad, 0);
      end
      // R7: burst increment
      xfer(4, 1, -1, 8'h10, 8'hA1, 8'hA2, 8'hA3, 0, 0);
      chk("R7 cnt", wn, 3);
      for (int i = 0; i < 3; i++) begin
        chk("R7 addr", wa[i], {bpg, 7'(8'h10 + i)});
        chk("R7 data", wd[i], 8'(8'hA1 + i));
      end
      // R4: short burst does not commit
      xfer(4, 1, -1, 8'h7C, 8'h00, 8'h11, 8'h10, 0, 0);
      xfer(2, 1, -1, 8'h20, 8'h77, 0, 0, 0, 0);
      chk("R4 short burst", wa[0], {bpg, 7'h20});
      // R4: wrong tag does not commit
      xfer(5, 1, -1, 8'h7C, 8'h00, 8'h11, 8'h10, 8'h21, 0);
      xfer(2, 1, -1, 8'h21, 8'h78, 0, 0, 0, 0);
      chk("R4 bad tag", wa[0], {bpg, 7'h21});
      // R11: aborted write and read
      xfer(2, 1, 13, 8'h30, 8'hFF, 0, 0, 0, 0);
      chk("R11 partial dropped", wn, 0);
      xfer(3, 1, 12, 8'hB0, 0, 0, 0, 0, 0);
      chk("R11 release", {30'd0, spi_sdo_oe, spi_sdio_oe}, 0);
      // Long-offset mode
      cfg_two_byte = 1'b1;
      xfer(5, 2, -1, 8'h7F, 8'hFD, 8'h00, 8'h10, 8'h20, 0);
      bpg[8] = 1'b0;
      chk("R12 long window", wn, 0);
      xfer(3, 2, -1, 8'h4B, 8'hE4, 8'h50, 0, 0, 0);
      chk("R5 addr low page", wa[0], 16'h4BE4);
      xfer(5, 2, -1, 8'h7F, 8'hFD, 8'h80, 8'h10, 8'h20, 0);
      bpg[8] = 1'b1;
      xfer(3, 2, -1, 8'h4B, 8'hE4, 8'h50, 0, 0, 0);
      chk("R6 commit", wa[0], 16'hCBE4);
      chk("R5 data", wd[0], 8'h50);
      // R6: burst from 7FFC
      xfer(6, 2, -1, 8'h7F, 8'hFC, 8'h55, 8'h00, 8'h10, 8'h20);
      chk("R6 early cnt", wn, 1);
      chk("R6 early addr", wa[0], 16'hFFFC);
      chk("R6 early data", wd[0], 8'h55);
      xfer(3, 2, -1, 8'h0B, 8'h00, 8'h66, 0, 0, 0);
      chk("R6 page kept", wa[0], 16'h8B00);
      // R8: long read
      xfer(4, 2, -1, 8'hC0, 8'h24, 0, 0, 0, 0);
      chk("R8 long rd0", rxb[0], fmem(16'hC024));
      chk("R8 long rd1", rxb[1], fmem(16'hC025));
      chk("R10 long pins", oe_bad, 0);
      xfer(5, 2, -1, 8'hFF, 8'hFD, 0, 0, 0, 0);
      chk("R6 window read", rxb[0], 8'h80);
      chk("R6 tag read", rxb[1], 8'h10);
      // R5 sweep over long offsets
      for (int k = 0; k < 12; k++) begin
        logic [14:0] o;
        o = 15'((k * 15'h0A73 + 3) & 15'h7FFF);
        if (o >= 15'h7FFD) continue;
        xfer(3, 2, -1, {1'b0, o[14:8]}, o[7:0], 8'(k) ^ 8'hC3, 0, 0, 0);
        chk("R5 sweep addr", wa[0], {bpg[8], o});
        chk("R5 sweep data", wd[0], 8'(k) ^ 8'hC3);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule